// File: doc/BRIEF.md
# Even-Ratio Event Prescaler

This block sits between an event synchroniser and the capture logic. It thins out a stream of single-cycle event pulses according to a 5-bit ratio code. Code zero is a pure bypass: each input pulse appears at the output in the same cycle. Any nonzero code N lets one pulse through for every 2N input pulses. The supported ratios are therefore 2, 4, 6 and so on, up to 62.

The ratio code is loaded through a write strobe. Every write restarts the event count from zero, so a new ratio always begins from a clean count. In divide mode the output pulse is combinational with the terminating input pulse and adds no latency. Edge detection, synchronisation and timestamp capture belong to neighbouring blocks.

Top module: `even_ratio_prescaler`

## Requirements
- R1: After reset the active ratio code reads 0 and no output pulse is produced unless an input pulse is present.
- R2: A cycle with `sel_wr` high loads `sel_wdata` into the active ratio code. The new value is visible on `cur_sel` from the next cycle.
- R3: With an active code of 0, `evt_out` equals `evt_in` in the same cycle for every cycle.
- R4: With an active code N (1..31), `evt_out` pulses in the same cycle as the 2N-th input pulse counted since the last output pulse or since the last write. The count then restarts.
- R5: `evt_out` is never high in a cycle where `evt_in` is low, so every output pulse lasts one cycle.
- R6: In a write cycle, `evt_out` is still decided by the old code and the old count. Input pulses that arrived before the write, including one in the write cycle itself, do not count toward the new ratio.
- R7: Code 31 divides by 62, and the internal count never reaches 2N.
- R8: Idle cycles between input pulses do not advance or disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Write strobe for the ratio code |
| sel_wdata | input | 5 | Ratio code to load (0 = bypass, N = divide by 2N) |
| evt_in | input | 1 | Single-cycle synchronised input event |
| evt_out | output | 1 | Single-cycle prescaled event |
| cur_sel | output | 5 | Active ratio code |

## Verification
The bench targets four corner cases.

The first is the bypass path. A design that registered it would show every output one cycle late.

The second is the terminal count. An off-by-one compare would divide by 2N-1 or 2N+1, or would emit the pulse a cycle after the 2N-th event.

The third is code 31. This exposes a counter that is too narrow or that wraps early, either of which would break the divide-by-62 spacing.

The fourth is a write that lands on top of an event. A design that failed to clear the count, or that counted the coincident event into the new ratio, would produce its next pulse early.

Sparse event patterns confirm that idle cycles leave the count untouched.

// File: rtl/eprs_pkg.sv
package eprs_pkg;
    localparam int SEL_W = 5;
    localparam int CNT_W = SEL_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0] code;
    } sel_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;
endpackage

// File: rtl/eprs_sel_reg.sv
module eprs_sel_reg
    import eprs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] wdata_i,
    output logic [SEL_W-1:0] sel_o
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.code = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.code;

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (sel_o == $past(wdata_i))); // R2
endmodule

// File: rtl/eprs_counter.sv
module eprs_counter
    import eprs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             evt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             bypass;

    assign limit  = {sel_i, 1'b0};
    assign bypass = (sel_i == '0);
    assign hit_o  = evt_i && !bypass && (st_q.cnt == limit - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (wr_i || bypass) begin
            st_d.cnt = '0;
        end else if (evt_i) begin
            st_d.cnt = hit_o ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.cnt == '0)); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (st_q.cnt < limit)); // R7
    AST_BYPASS_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (st_q.cnt == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !wr_i) |=> $stable(st_q.cnt)); // R8
    AST_WRAP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (st_q.cnt == '0)); // R4
endmodule

// File: rtl/eprs_out_stage.sv
module eprs_out_stage
    import eprs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             evt_i,
    input  logic             hit_i,
    output logic             evt_o
);
    always_comb begin
        evt_o = hit_i;
        if (sel_i == '0) evt_o = evt_i;
    end

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> evt_i); // R5
endmodule

// File: rtl/even_ratio_prescaler.sv
module even_ratio_prescaler
    import eprs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             evt_in,
    output logic             evt_out,
    output logic [SEL_W-1:0] cur_sel
);
    logic [SEL_W-1:0] sel_q;
    logic             hit;

    eprs_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sel_wr),
        .wdata_i (sel_wdata),
        .sel_o   (sel_q)
    );

    eprs_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (sel_wr),
        .evt_i (evt_in),
        .sel_i (sel_q),
        .hit_o (hit)
    );

    eprs_out_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel_q),
        .evt_i (evt_in),
        .hit_i (hit),
        .evt_o (evt_out)
    );

    assign cur_sel = sel_q;
endmodule

// File: tb/tb_even_ratio_prescaler.sv
module tb_even_ratio_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [4:0]  code;
        logic [3:0]  gap;
        logic [7:0]  nevt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  4'd0, 8'd5},
        '{5'd0,  4'd2, 8'd4},
        '{5'd1,  4'd0, 8'd6},
        '{5'd1,  4'd1, 8'd6},
        '{5'd2,  4'd0, 8'd9},
        '{5'd3,  4'd3, 8'd12},
        '{5'd31, 4'd0, 8'd130},
        '{5'd5,  4'd0, 8'd25},
        '{5'd31, 4'd1, 8'd62}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       sel_wr = 0;
    logic [4:0] sel_wdata = 0;
    logic       evt_in = 0;
    logic       evt_out;
    logic [4:0] cur_sel;

    int checks = 0;
    int fails = 0;
    int m_sel = 0;
    int m_cnt = 0;
    int n_out = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    even_ratio_prescaler dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .evt_in(evt_in), .evt_out(evt_out), .cur_sel(cur_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the output, update the model
    task automatic step(input logic e, input logic w, input logic [4:0] wd, input string tag);
        int exp;
        @(negedge clk);
        evt_in = e; sel_wr = w; sel_wdata = wd;
        #(CLK_PERIOD/4);
        exp = (e && (m_sel == 0 || m_cnt == 2*m_sel - 1)) ? 1 : 0;
        check(tag, int'(evt_out), exp);
        if (evt_out) n_out++;
        if (w) begin m_sel = wd; m_cnt = 0; end
        else if (m_sel == 0) m_cnt = 0;
        else if (e) m_cnt = exp ? 0 : m_cnt + 1;
    endtask

    task automatic write_sel(input logic [4:0] code);
        step(1'b0, 1'b1, code, "R2 write");
        step(1'b0, 1'b0, 5'd0, "R5 idle");
        check("R2 cur_sel", int'(cur_sel), int'(code));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD/4);
        check("R1 reset evt_out", int'(evt_out), 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        #(CLK_PERIOD/4);
        check("R1 reset cur_sel", int'(cur_sel), 0);
        step(1'b1, 1'b0, 5'd0, "R3 bypass after reset");

        for (int v = 0; v < NVEC; v++) begin
            int exp_n;
            write_sel(VECS[v].code);
            n_out = 0;
            for (int i = 0; i < int'(VECS[v].nevt); i++) begin
                step(1'b1, 1'b0, 5'd0, VECS[v].code == 0 ? "R3 bypass" : "R4 divide");
                for (int g = 0; g < int'(VECS[v].gap); g++)
                    step(1'b0, 1'b0, 5'd0, "R8 gap");
            end
            exp_n = (VECS[v].code == 0) ? int'(VECS[v].nevt)
                                        : int'(VECS[v].nevt) / (2 * int'(VECS[v].code));
            check("R4 R7 pulse total", n_out, exp_n);
        end

        // R7: exact position of the first pulse at code 31
        write_sel(5'd31);
        for (int i = 1; i <= 62; i++) begin
            step(1'b1, 1'b0, 5'd0, "R7 code31");
            if (i == 61) check("R7 no pulse at 61", int'(evt_out), 0);
            if (i == 62) check("R7 pulse at 62", int'(evt_out), 1);
        end

        // R6: a write that coincides with an event
        write_sel(5'd2);
        step(1'b1, 1'b0, 5'd0, "R6 pre");
        step(1'b1, 1'b0, 5'd0, "R6 pre");
        step(1'b1, 1'b1, 5'd2, "R6 write with event");
        check("R6 no pulse in write cycle", int'(evt_out), 0);
        for (int i = 1; i <= 4; i++) begin
            step(1'b1, 1'b0, 5'd0, "R6 after write");
            check("R6 restart count", int'(evt_out), (i == 4) ? 1 : 0);
        end

        // R6: a write on the terminal event still pulses under the old code
        step(1'b1, 1'b0, 5'd0, "R6 a");
        step(1'b1, 1'b0, 5'd0, "R6 b");
        step(1'b1, 1'b0, 5'd0, "R6 c");
        step(1'b1, 1'b1, 5'd1, "R6 terminal write");
        check("R6 old code decides", int'(evt_out), 1);
        step(1'b1, 1'b0, 5'd0, "R6 new code first");
        check("R6 new code first", int'(evt_out), 0);
        step(1'b1, 1'b0, 5'd0, "R6 new code second");
        check("R6 new code second", int'(evt_out), 1);

        // R5: no pulse without an event in bypass mode either
        write_sel(5'd0);
        step(1'b0, 1'b0, 5'd0, "R5 bypass idle");
        check("R5 bypass idle", int'(evt_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule